// File: doc/BRIEF.md
# Video Memory Write Steering

This block sits between a CPU store path and a 96 KiB video memory built from two halfword-wide banks. Each cycle it may accept one store (an address, a size of byte, halfword or word, the store data, and the 3-bit background mode currently set in the display-control register). One clock later it drives the write ports of the two banks. Bank "even" holds the halfwords whose byte offset has bit 1 clear, and bank "odd" holds those with bit 1 set. Both banks are indexed by row = offset[16:2].

Only the low 17 address bits select a location. Offsets 0x18000 to 0x1FFFF fold back onto 0x10000 to 0x17FFF. Word and halfword stores are aligned down to their size and written unchanged. Byte stores never write a single byte. The byte is copied into both halves of a halfword and written to the halfword-aligned offset. If the folded offset lies in the sprite-data area for the current mode, the byte store is discarded.

Top module: `vram_write_steer`

## Requirements
- R1: Port outputs are registered. A store presented in cycle k drives the bank ports in cycle k+1. During reset, and in any cycle after a cycle with req_valid low, both write enables (ev_we, od_we) are 0.
- R2: A word store (req_size = 2'b10) is written to the folded offset with bits 1:0 cleared. wdata[15:0] goes to the even bank and wdata[31:16] to the odd bank, on the same row, with both byte enables set. This gives little-endian byte order in memory.
- R3: A halfword store (req_size = 2'b01) writes wdata[15:0] to the folded offset with bit 0 cleared, in the bank selected by offset bit 1, with both byte enables set.
- R4: A byte store (req_size = 2'b00) that is not discarded writes {wdata[7:0], wdata[7:0]} to both bytes of the halfword at the folded offset with bit 0 cleared.
- R5: With background mode 0, 1 or 2, a byte store whose folded offset is 0x10000 or above writes nothing. Below 0x10000 it is stored.
- R6: With background mode 3 to 7, a byte store whose folded offset is 0x14000 or above writes nothing. A byte store to 0x10000 to 0x13FFF is stored.
- R7: Address bits 23:17 are ignored. A window offset of 0x18000 or above is reduced by 0x8000 before alignment and before the region checks of R5 and R6.
- R8: A store with req_size = 2'b11 writes nothing.
- R9: The background mode is taken from req_bg_mode in the same cycle as each store. Back-to-back stores with different modes are each judged by their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request strobe |
| req_addr | input | 24 | Store byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_wdata | input | 32 | Store data, right-aligned |
| req_bg_mode | input | 3 | Background mode from display control |
| ev_we | output | 1 | Even bank write enable |
| ev_row | output | 15 | Even bank row |
| ev_be | output | 2 | Even bank byte enables |
| ev_data | output | 16 | Even bank write data |
| od_we | output | 1 | Odd bank write enable |
| od_row | output | 15 | Odd bank row |
| od_be | output | 2 | Odd bank byte enables |
| od_data | output | 16 | Odd bank write data |

## Verification
The bench applies the bank ports to a behavioural memory and compares it with a byte-array model of the store rules after every cycle. Directed byte stores land on either side of 0x10000 and 0x14000 in both mode groups. This shows whether the correct limit is applied and whether it is inclusive. Further byte stores go to folded addresses such as 0x18000 and 0x1C000, and to addresses with high bits set. These separate a check on the raw address from a check on the folded offset. Odd and unaligned word, halfword and byte offsets expose errors in alignment, lane order and bank choice. A long run with random sizes, modes and idle cycles then catches interactions, including a mode change between consecutive stores.

// File: rtl/vram_ws_pkg.sv
package vram_ws_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;
endpackage

// File: rtl/vram_addr_fold.sv
module vram_addr_fold #(
  parameter int OFF_W     = 17,
  parameter int MEM_BYTES = 98304
) (
  input  logic [OFF_W-1:0] win_off,
  input  logic [1:0]       size,
  output logic [OFF_W-1:0] off_mirror,
  output logic [OFF_W-1:0] off_aligned
);
  import vram_ws_pkg::*;
  localparam int WIN_BYTES = 1 << OFF_W;
  localparam logic [OFF_W-1:0] FOLD_STEP = OFF_W'(WIN_BYTES - MEM_BYTES);
  localparam logic [OFF_W-1:0] TOP_LIM   = OFF_W'(MEM_BYTES);

  always_comb begin
    if (win_off >= TOP_LIM) off_mirror = win_off - FOLD_STEP;
    else                    off_mirror = win_off;
  end

  always_comb begin
    off_aligned = off_mirror;
    if (size == SZ_WORD) off_aligned[1:0] = 2'b00;
    else                 off_aligned[0]   = 1'b0;
  end
endmodule

// File: rtl/vram_byte_gate.sv
module vram_byte_gate #(
  parameter int OFF_W        = 17,
  parameter int MODE_W       = 3,
  parameter int TILE_MODE_MAX = 2,
  parameter int TILE_LIMIT   = 'h10000,
  parameter int BMP_LIMIT    = 'h14000
) (
  input  logic [OFF_W-1:0]  off_mirror,
  input  logic [MODE_W-1:0] bg_mode,
  input  logic              is_byte,
  output logic              drop
);
  localparam logic [OFF_W-1:0]  TILE_LIM = OFF_W'(TILE_LIMIT);
  localparam logic [OFF_W-1:0]  BMP_LIM  = OFF_W'(BMP_LIMIT);
  localparam logic [MODE_W-1:0] TMAX     = MODE_W'(TILE_MODE_MAX);

  logic [OFF_W-1:0] limit;

  always_comb begin
    if (bg_mode <= TMAX) limit = TILE_LIM;
    else                 limit = BMP_LIM;
    drop = is_byte && (off_mirror >= limit);
  end
endmodule

// File: rtl/vram_lane_steer.sv
module vram_lane_steer #(
  parameter int OFF_W  = 17,
  parameter int DATA_W = 32,
  parameter int HW_W   = 16,
  parameter int BANKS  = 2
) (
  input  logic                   valid,
  input  logic [1:0]             size,
  input  logic [OFF_W-1:1]       off_hw,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   drop,
  output logic [BANKS-1:0]       bank_we,
  output logic [OFF_W-3:0]       bank_row [BANKS],
  output logic [HW_W/8-1:0]      bank_be  [BANKS],
  output logic [HW_W-1:0]        bank_data[BANKS]
);
  import vram_ws_pkg::*;
  localparam int BE_W = HW_W / 8;

  logic accept;
  assign accept = valid && (size != SZ_RSVD) && !drop;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    always_comb begin
      hit = (size == SZ_WORD) || (off_hw[1] == b[0]);
      bank_we[b]  = accept && hit;
      bank_row[b] = off_hw[OFF_W-1:2];
      bank_be[b]  = bank_we[b] ? {BE_W{1'b1}} : {BE_W{1'b0}};
      case (size)
        SZ_WORD: bank_data[b] = wdata[b*HW_W +: HW_W];
        SZ_HALF: bank_data[b] = wdata[HW_W-1:0];
        default: bank_data[b] = {2{wdata[7:0]}};
      endcase
    end
  end
endmodule

// File: rtl/vram_write_steer.sv
module vram_write_steer #(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 32,
  parameter int HW_W          = 16,
  parameter int MODE_W        = 3,
  parameter int OFF_W         = 17,
  parameter int MEM_BYTES     = 98304,
  parameter int TILE_MODE_MAX = 2,
  parameter int TILE_LIMIT    = 'h10000,
  parameter int BMP_LIMIT     = 'h14000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MODE_W-1:0] req_bg_mode,
  output logic              ev_we,
  output logic [OFF_W-3:0]  ev_row,
  output logic [HW_W/8-1:0] ev_be,
  output logic [HW_W-1:0]   ev_data,
  output logic              od_we,
  output logic [OFF_W-3:0]  od_row,
  output logic [HW_W/8-1:0] od_be,
  output logic [HW_W-1:0]   od_data
);
  import vram_ws_pkg::*;
  localparam int BANKS = 2;
  localparam int ROW_W = OFF_W - 2;
  localparam int BE_W  = HW_W / 8;

  logic unused_hi;
  assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];

  logic [OFF_W-1:0] off_mirror, off_aligned;
  logic             drop;
  logic [BANKS-1:0] n_we;
  logic [ROW_W-1:0] n_row  [BANKS];
  logic [BE_W-1:0]  n_be   [BANKS];
  logic [HW_W-1:0]  n_data [BANKS];
  logic             unused_b0;
  assign unused_b0 = off_aligned[0];

  vram_addr_fold #(.OFF_W(OFF_W), .MEM_BYTES(MEM_BYTES)) u_fold (
    .win_off     (req_addr[OFF_W-1:0]),
    .size        (req_size),
    .off_mirror  (off_mirror),
    .off_aligned (off_aligned)
  );

  vram_byte_gate #(
    .OFF_W(OFF_W), .MODE_W(MODE_W), .TILE_MODE_MAX(TILE_MODE_MAX),
    .TILE_LIMIT(TILE_LIMIT), .BMP_LIMIT(BMP_LIMIT)
  ) u_gate (
    .off_mirror (off_mirror),
    .bg_mode    (req_bg_mode),
    .is_byte    (req_size == SZ_BYTE),
    .drop       (drop)
  );

  vram_lane_steer #(.OFF_W(OFF_W), .DATA_W(DATA_W), .HW_W(HW_W), .BANKS(BANKS)) u_steer (
    .valid     (req_valid),
    .size      (req_size),
    .off_hw    (off_aligned[OFF_W-1:1]),
    .wdata     (req_wdata),
    .drop      (drop),
    .bank_we   (n_we),
    .bank_row  (n_row),
    .bank_be   (n_be),
    .bank_data (n_data)
  );

  // Data-path registers load only when a bank is written; enables always update.
  logic ev_load, od_load;
  assign ev_load = n_we[0];
  assign od_load = n_we[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_we <= 1'b0;
      od_we <= 1'b0;
    end else begin
      ev_we <= n_we[0];
      od_we <= n_we[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_row  <= '0;
      ev_be   <= '0;
      ev_data <= '0;
    end else if (ev_load) begin
      ev_row  <= n_row[0];
      ev_be   <= n_be[0];
      ev_data <= n_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_row  <= '0;
      od_be   <= '0;
      od_data <= '0;
    end else if (od_load) begin
      od_row  <= n_row[1];
      od_be   <= n_be[1];
      od_data <= n_data[1];
    end
  end
endmodule

// File: rtl/vram_write_steer_chk.sv
module vram_write_steer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [23:0] req_addr,
  input logic [1:0]  req_size,
  input logic [2:0]  req_bg_mode,
  input logic        ev_we,
  input logic [14:0] ev_row,
  input logic [15:0] ev_data,
  input logic        od_we,
  input logic [14:0] od_row,
  input logic [15:0] od_data
);
  // R1: idle cycle produces no write
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ev_we && !od_we);

  // R2: word store writes both banks on one row
  a_r2_word_both: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b10 |=> ev_we && od_we && ev_row == od_row);

  // R3: halfword store touches exactly one bank
  a_r3_half_one: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b01 |=> $countones({ev_we, od_we}) == 1);

  // R4: byte store data is replicated into both bytes
  a_r4_byte_repl: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b00 |=>
      (!ev_we || ev_data[15:8] == ev_data[7:0]) && (!od_we || od_data[15:8] == od_data[7:0])
      && $countones({ev_we, od_we}) <= 1);

  // R5 R7: tile modes, any folded offset at or above 0x10000 has window bit 16 set
  a_r5_tile_drop: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b00 && req_bg_mode <= 3'd2 && req_addr[16] |=> !ev_we && !od_we);

  // R6 R7: bitmap modes, folded offset at or above 0x14000 means bits 16 and 14 set
  a_r6_bmp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b00 && req_bg_mode > 3'd2 && req_addr[16] && req_addr[14]
      |=> !ev_we && !od_we);

  // R6: bitmap mode byte store into 0x10000..0x13FFF is kept
  a_r6_bmp_keep: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b00 && req_bg_mode > 3'd2 && req_addr[16] && !req_addr[14]
      |=> $countones({ev_we, od_we}) == 1);

  // R8: reserved size writes nothing
  a_r8_rsvd_none: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b11 |=> !ev_we && !od_we);
endmodule

bind vram_write_steer vram_write_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .req_bg_mode(req_bg_mode),
  .ev_we(ev_we), .ev_row(ev_row), .ev_data(ev_data),
  .od_we(od_we), .od_row(od_row), .od_data(od_data)
);

// File: tb/vram_write_steer_test.sv
module vram_write_steer_test;
  logic        clk, rst_n;
  logic        req_valid;
  logic [23:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [2:0]  req_bg_mode;
  logic        ev_we, od_we;
  logic [14:0] ev_row, od_row;
  logic [1:0]  ev_be, od_be;
  logic [15:0] ev_data, od_data;

  vram_write_steer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_bg_mode(req_bg_mode),
    .ev_we(ev_we), .ev_row(ev_row), .ev_be(ev_be), .ev_data(ev_data),
    .od_we(od_we), .od_row(od_row), .od_be(od_be), .od_data(od_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] sink [int];
  logic [7:0] refm [int];

  bit    prev_act = 0;
  int    prev_word = 0;
  int    prev_cnt = 0;
  string prev_tag = "R1";

  function automatic logic [7:0] sb(int i);
    return sink.exists(i) ? sink[i] : 8'h00;
  endfunction
  function automatic logic [7:0] rb(int i);
    return refm.exists(i) ? refm[i] : 8'h00;
  endfunction

  function automatic int fold(logic [23:0] a);
    int o;
    o = int'(a[16:0]);
    if (o >= 'h18000) o = o - 'h8000;
    return o;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply_ports();
    if (ev_we) begin
      if (ev_be[0]) sink[int'(ev_row)*4 + 0] = ev_data[7:0];
      if (ev_be[1]) sink[int'(ev_row)*4 + 1] = ev_data[15:8];
    end
    if (od_we) begin
      if (od_be[0]) sink[int'(od_row)*4 + 2] = od_data[7:0];
      if (od_be[1]) sink[int'(od_row)*4 + 3] = od_data[15:8];
    end
  endtask

  task automatic verify_prev();
    int cnt;
    cnt = int'(ev_we) + int'(od_we);
    check(cnt == prev_cnt, prev_tag, "bank write count", cnt, prev_cnt);
    if (prev_act)
      for (int i = 0; i < 4; i++)
        check(sb(prev_word + i) == rb(prev_word + i), prev_tag, "memory byte",
              int'(sb(prev_word + i)), int'(rb(prev_word + i)));
  endtask

  // One cycle: settle last cycle's outputs, check them, then present a new request.
  task automatic cyc(bit v, logic [23:0] a, logic [1:0] sz, logic [31:0] d,
                     logic [2:0] m, string tag_in);
    int o, al, lim, cnt;
    string tag;
    @(negedge clk);
    apply_ports();
    verify_prev();
    req_valid = v; req_addr = a; req_size = sz; req_wdata = d; req_bg_mode = m;
    o = fold(a);
    cnt = 0;
    tag = tag_in;
    if (!v) begin
      if (tag == "") tag = "R1";
    end else if (sz == 2'b10) begin
      al = o & ~3;
      for (int i = 0; i < 4; i++) refm[al + i] = d[8*i +: 8];
      cnt = 2;
      if (tag == "") tag = (int'(a[16:0]) >= 'h18000) ? "R7" : "R2";
    end else if (sz == 2'b01) begin
      al = o & ~1;
      refm[al] = d[7:0]; refm[al + 1] = d[15:8];
      cnt = 1;
      if (tag == "") tag = (int'(a[16:0]) >= 'h18000) ? "R7" : "R3";
    end else if (sz == 2'b00) begin
      lim = (m <= 3'd2) ? 'h10000 : 'h14000;
      if (o >= lim) begin
        if (tag == "") tag = (int'(a[16:0]) >= 'h18000) ? "R7" : ((m <= 3'd2) ? "R5" : "R6");
      end else begin
        al = o & ~1;
        refm[al] = d[7:0]; refm[al + 1] = d[7:0];
        cnt = 1;
        if (tag == "") tag = (int'(a[16:0]) >= 'h18000) ? "R7" : "R4";
      end
    end else begin
      if (tag == "") tag = "R8";
    end
    prev_act  = v;
    prev_word = o & ~3;
    prev_cnt  = cnt;
    prev_tag  = tag;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mism;
    req_valid = 0; req_addr = '0; req_size = '0; req_wdata = '0; req_bg_mode = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!ev_we && !od_we, "R1", "enables in reset", int'({ev_we, od_we}), 0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, "R1");
    // Word and halfword layout, unaligned offsets
    cyc(1, 24'h000103, 2'b10, 32'hA1B2C3D4, 3'd0, "R2");
    cyc(1, 24'h000207, 2'b01, 32'hFFFF5678, 3'd0, "R3");
    cyc(1, 24'h000205, 2'b01, 32'h00009ABC, 3'd3, "R3");
    // Byte replication, odd offset in both banks
    cyc(1, 24'h000301, 2'b00, 32'h000000E7, 3'd0, "R4");
    cyc(1, 24'h000303, 2'b00, 32'h0000003C, 3'd4, "R4");
    // Prefill the boundary areas with words so dropped bytes would show
    cyc(1, 24'h00FFFC, 2'b10, 32'h11111111, 3'd0, "R2");
    cyc(1, 24'h010000, 2'b10, 32'h22222222, 3'd0, "R2");
    cyc(1, 24'h013FFC, 2'b10, 32'h33333333, 3'd0, "R2");
    cyc(1, 24'h014000, 2'b10, 32'h44444444, 3'd0, "R2");
    // Tile-mode boundary
    cyc(1, 24'h00FFFF, 2'b00, 32'h000000AA, 3'd0, "R5");
    cyc(1, 24'h010000, 2'b00, 32'h000000BB, 3'd1, "R5");
    cyc(1, 24'h010001, 2'b00, 32'h000000BC, 3'd2, "R5");
    // Bitmap-mode boundary
    cyc(1, 24'h010000, 2'b00, 32'h000000CC, 3'd3, "R6");
    cyc(1, 24'h013FFF, 2'b00, 32'h000000DD, 3'd4, "R6");
    cyc(1, 24'h014000, 2'b00, 32'h000000EE, 3'd5, "R6");
    cyc(1, 24'h014000, 2'b00, 32'h000000EF, 3'd7, "R6");
    // Folding: checks act on folded offset, high bits ignored
    cyc(1, 24'h018000, 2'b00, 32'h00000071, 3'd3, "R7");
    cyc(1, 24'h01C000, 2'b00, 32'h00000072, 3'd3, "R7");
    cyc(1, 24'hFE0120, 2'b10, 32'h0BADF00D, 3'd0, "R7");
    cyc(1, 24'h01FFFE, 2'b10, 32'hCAFEBABE, 3'd0, "R7");
    // Reserved size
    cyc(1, 24'h000400, 2'b11, 32'h12345678, 3'd0, "R8");
    // Mode taken per store, back to back
    cyc(1, 24'h012002, 2'b00, 32'h00000055, 3'd0, "R9");
    cyc(1, 24'h012002, 2'b00, 32'h00000066, 3'd3, "R9");
    cyc(1, 24'h012002, 2'b00, 32'h00000077, 3'd2, "R9");
    // Random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] a;
      a = 24'($urandom);
      if (($urandom % 4) == 0) begin
        case ($urandom % 4)
          0: a[16:0] = 17'h10000 + 17'($urandom % 8) - 17'd4;
          1: a[16:0] = 17'h14000 + 17'($urandom % 8) - 17'd4;
          2: a[16:0] = 17'h18000 + 17'($urandom % 8) - 17'd4;
          default: a[16:0] = 17'h1C000 + 17'($urandom % 8) - 17'd4;
        endcase
      end
      cyc(($urandom % 10) != 0, a, 2'($urandom), $urandom, 3'($urandom), "");
    end
    cyc(0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, "R1");
    mism = 0;
    foreach (sink[k]) if (sb(k) != rb(k)) mism++;
    foreach (refm[k]) if (sb(k) != rb(k)) mism++;
    check(mism == 0, "R2", "full memory image mismatches", mism, 0);
    finish_run();
  end
endmodule